// File: doc/BRIEF.md
# SIMT Branch Divergence Controller

This block tracks which lanes of a single warp are enabled as the warp runs through conditional branches. Each issued instruction reports whether it is a branch. For a branch it also gives a per-lane taken vector, the branch target, the fall-through address and the address where the two paths meet again. The controller returns the address of the next instruction to fetch and the lane mask that goes with it. When the enabled lanes all agree on a direction, the controller just follows that direction.

When the enabled lanes split, the controller runs the taken lanes first. It then runs the not-taken lanes, and at the meeting point it restores the mask that was in force before the branch. The pending work is held on a small stack. Each split takes two entries: one that resumes the merged lanes at the meeting point, and one that holds the not-taken path. A launch pulse starts the warp at a given address with every lane enabled and empties the stack.

When the current path reaches its meeting point and the stack is not empty, the controller spends one cycle restoring the top entry. During that cycle it raises a settle flag, and the fetch side must not issue. Each warp has its own instance, so separate warps never interact.

Top module: `simt_diverge_ctrl`

## Requirements
- R1: After reset, pc_o is 0, mask_o has every lane set, and settle_o and overflow_o are low.
- R2: A cycle with start_i high loads pc_o with start_pc_i and sets every lane in mask_o. It also empties the stack and clears overflow_o. It takes priority over an issue or a restore in the same cycle.
- R3: An issued non-branch instruction loads pc_o with next_pc_i on the next clock and leaves mask_o unchanged.
- R4: An issued branch whose enabled lanes all have their taken_i bit set (bit i belongs to lane i, and 1 means taken) loads pc_o with target_pc_i and leaves mask_o unchanged. Nothing is pushed.
- R5: An issued branch whose enabled lanes all have their taken_i bit clear loads pc_o with next_pc_i and leaves mask_o unchanged. Nothing is pushed.
- R6: The taken_i bits of lanes that are clear in mask_o have no effect on the direction, the mask or the stack.
- R7: When the enabled lanes disagree, pc_o becomes target_pc_i and mask_o becomes mask_o AND taken_i.
- R8: While the stack is not empty and pc_o equals the meeting point of the current path, settle_o is high. The next clock restores the top entry. After the taken path, the controller resumes at the fall-through address with the original mask AND NOT taken_i. After the not-taken path, it resumes at the meeting point with the original mask.
- R9: issue_i has no effect while settle_o is high.
- R10: A split that needs more than DEPTH stack entries (each split takes two) sets overflow_o and leaves pc_o and mask_o unchanged. overflow_o then stays high until start_i.
- R11: Nested splits restore the inner masks first and then the outer ones, each at its own meeting point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the warp with every lane enabled |
| start_pc_i | input | PC_W | Launch address |
| issue_i | input | 1 | An instruction at pc_o issues this cycle |
| branch_i | input | 1 | The issued instruction is a conditional branch |
| taken_i | input | LANES | Per-lane taken predicate, 1 = taken |
| target_pc_i | input | PC_W | Branch target address |
| next_pc_i | input | PC_W | Fall-through address |
| reconv_pc_i | input | PC_W | Meeting point of the two branch paths |
| pc_o | output | PC_W | Address of the next instruction |
| mask_o | output | LANES | Enabled lanes for that instruction |
| settle_o | output | 1 | Restore cycle: do not issue |
| overflow_o | output | 1 | A split was dropped for lack of stack space |

## Verification
Two functions can fall in the same cycle: a launch and a pending restore, or a launch and an issued diverging branch. To provoke them, start_i is raised in the cycle where settle_o is high, and also together with a split branch. The check is that the launch address and a full mask win, that the stack is empty afterwards, and that the warp therefore runs to the old meeting point without a settle cycle. The bench also sweeps every taken pattern on an 8-lane warp and follows each split through both paths and back to the merged mask.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef enum logic [1:0] {
    DIR_FALL  = 2'd0,
    DIR_TAKE  = 2'd1,
    DIR_SPLIT = 2'd2
  } dir_e;
endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split
  import simt_div_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             branch_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [LANES-1:0] taken_i,
  output dir_e             dir_o,
  output logic [LANES-1:0] take_mask_o,
  output logic [LANES-1:0] fall_mask_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign take_mask_o[l] = mask_i[l] & taken_i[l];
    assign fall_mask_o[l] = mask_i[l] & ~taken_i[l];
  end

  always_comb begin
    if (!branch_i || take_mask_o == '0) dir_o = DIR_FALL;
    else if (fall_mask_o == '0)         dir_o = DIR_TAKE;
    else                                dir_o = DIR_SPLIT;
  end
endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
  parameter int ENT_W = 64,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [ENT_W-1:0] push_lo_i,
  input  logic [ENT_W-1:0] push_hi_i,
  input  logic             pop_i,
  output logic [ENT_W-1:0] top_o,
  output logic             empty_o,
  output logic             no_room_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign empty_o   = (cnt_q == '0);
  // a split needs two free slots
  assign no_room_o = (32'(cnt_q) + 2 > DEPTH);
  assign top_o     = mem_q[IDX_W'(cnt_q - CNT_W'(1))];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (push_i)  cnt_q <= cnt_q + CNT_W'(2);
    else if (pop_i)   cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) begin
      mem_q[IDX_W'(cnt_q)]               <= push_lo_i;
      mem_q[IDX_W'(cnt_q + CNT_W'(1))]   <= push_hi_i;
    end
  end
endmodule

// File: rtl/simt_diverge_ctrl.sv
module simt_diverge_ctrl
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic             issue_i,
  input  logic             branch_i,
  input  logic [LANES-1:0] taken_i,
  input  logic [PC_W-1:0]  target_pc_i,
  input  logic [PC_W-1:0]  next_pc_i,
  input  logic [PC_W-1:0]  reconv_pc_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] mask_o,
  output logic             settle_o,
  output logic             overflow_o
);
  localparam int ENT_W = 2 * PC_W + LANES;

  logic [PC_W-1:0]  pc_q, rpc_q;
  logic [LANES-1:0] mask_q, take_mask, fall_mask;
  logic             ovf_q, empty, no_room, go, push, pop;
  logic [ENT_W-1:0] ent_lo, ent_hi, top;
  dir_e             dir;

  simt_lane_split #(.LANES(LANES)) u_split (
    .branch_i    (branch_i),
    .mask_i      (mask_q),
    .taken_i     (taken_i),
    .dir_o       (dir),
    .take_mask_o (take_mask),
    .fall_mask_o (fall_mask)
  );

  // entry layout: {meeting point of the path, resume pc, mask}
  assign ent_lo = {rpc_q, reconv_pc_i, mask_q};
  assign ent_hi = {reconv_pc_i, next_pc_i, fall_mask};

  assign settle_o   = !empty && (pc_q == rpc_q);
  assign go         = issue_i && !settle_o && !start_i;
  assign push       = go && (dir == DIR_SPLIT) && !no_room;
  assign pop        = settle_o && !start_i;

  simt_recon_stack #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .push_i    (push),
    .push_lo_i (ent_lo),
    .push_hi_i (ent_hi),
    .pop_i     (pop),
    .top_o     (top),
    .empty_o   (empty),
    .no_room_o (no_room)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      rpc_q  <= '0;
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else if (start_i) begin
      pc_q   <= start_pc_i;
      rpc_q  <= '0;
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else if (pop) begin
      {rpc_q, pc_q, mask_q} <= top;
    end else if (go) begin
      unique case (dir)
        DIR_FALL: pc_q <= next_pc_i;
        DIR_TAKE: pc_q <= target_pc_i;
        default: begin
          if (no_room) ovf_q <= 1'b1;
          else begin
            pc_q   <= target_pc_i;
            mask_q <= take_mask;
            rpc_q  <= reconv_pc_i;
          end
        end
      endcase
    end
  end

  assign pc_o       = pc_q;
  assign mask_o     = mask_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/simt_diverge_ctrl_chk.sv
module simt_diverge_ctrl_chk #(
  parameter int LANES = 32,
  parameter int PC_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [PC_W-1:0]  start_pc_i,
  input logic             issue_i,
  input logic             branch_i,
  input logic [LANES-1:0] taken_i,
  input logic [PC_W-1:0]  target_pc_i,
  input logic [PC_W-1:0]  next_pc_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [LANES-1:0] mask_o,
  input logic             settle_o,
  input logic             overflow_o
);
  logic live;
  assign live = issue_i && !settle_o && !start_i;

  assert_start_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pc_o == $past(start_pc_i)) && (mask_o == '1) && !overflow_o);

  assert_plain_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !branch_i) |=> (pc_o == $past(next_pc_i)) && (mask_o == $past(mask_o)));

  assert_uniform_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && branch_i && ((mask_o & ~taken_i) == '0)) |=>
      (pc_o == $past(target_pc_i)) && (mask_o == $past(mask_o)));

  assert_split_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && branch_i && ((mask_o & taken_i) != '0) && ((mask_o & ~taken_i) != '0)) |=>
      overflow_o || (mask_o == $past(mask_o & taken_i)));

  assert_mask_nonempty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o != '0);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !start_i) |=> overflow_o);
endmodule

bind simt_diverge_ctrl simt_diverge_ctrl_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_pc_i(start_pc_i),
  .issue_i(issue_i), .branch_i(branch_i), .taken_i(taken_i),
  .target_pc_i(target_pc_i), .next_pc_i(next_pc_i), .pc_o(pc_o),
  .mask_o(mask_o), .settle_o(settle_o), .overflow_o(overflow_o)
);

// File: tb/simt_diverge_ctrl_bench.sv
module simt_diverge_ctrl_bench;
  localparam int LANES = 8;
  localparam int PC_W  = 8;
  localparam int DEPTH = 4;

  logic             clk = 1'b0, rst_ni = 1'b0;
  logic             start_i = 0, issue_i = 0, branch_i = 0;
  logic [PC_W-1:0]  start_pc_i = '0, target_pc_i = '0, next_pc_i = '0, reconv_pc_i = '0;
  logic [LANES-1:0] taken_i = '0;
  logic [PC_W-1:0]  pc_o;
  logic [LANES-1:0] mask_o;
  logic             settle_o, overflow_o;
  int               n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  simt_diverge_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_simt_diverge_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_pc_i(start_pc_i),
    .issue_i(issue_i), .branch_i(branch_i), .taken_i(taken_i),
    .target_pc_i(target_pc_i), .next_pc_i(next_pc_i), .reconv_pc_i(reconv_pc_i),
    .pc_o(pc_o), .mask_o(mask_o), .settle_o(settle_o), .overflow_o(overflow_o)
  );

  task automatic check(string req, logic [PC_W-1:0] epc, logic [LANES-1:0] emask,
                       logic eset, logic eovf);
    n_run++;
    if (pc_o !== epc || mask_o !== emask || settle_o !== eset || overflow_o !== eovf) begin
      n_fail++;
      $display("FAIL %s: pc=%h mask=%h settle=%b ovf=%b, expected pc=%h mask=%h settle=%b ovf=%b",
               req, pc_o, mask_o, settle_o, overflow_o, epc, emask, eset, eovf);
    end
  endtask

  task automatic launch(logic [PC_W-1:0] a);
    start_i = 1; start_pc_i = a;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic issue(logic br, logic [LANES-1:0] tk, logic [PC_W-1:0] tgt,
                       logic [PC_W-1:0] nxt, logic [PC_W-1:0] rcv);
    issue_i = 1; branch_i = br; taken_i = tk;
    target_pc_i = tgt; next_pc_i = nxt; reconv_pc_i = rcv;
    @(negedge clk);
    issue_i = 0; branch_i = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset", 8'h00, 8'hFF, 0, 0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 after release", 8'h00, 8'hFF, 0, 0);

    issue(0, 8'h00, 8'h00, 8'h07, 8'h00);
    check("R3 plain", 8'h07, 8'hFF, 0, 0);

    // sweep every taken pattern from a full mask
    for (int p = 0; p < 256; p++) begin
      logic [LANES-1:0] t;
      t = LANES'(p);
      launch(8'h10);
      check("R2 launch", 8'h10, 8'hFF, 0, 0);
      issue(1, t, 8'h20, 8'h11, 8'h30);
      if (t == 8'h00) check("R5 uniform fall", 8'h11, 8'hFF, 0, 0);
      else if (t == 8'hFF) check("R4 uniform take", 8'h20, 8'hFF, 0, 0);
      else begin
        check("R7 split", 8'h20, t, 0, 0);
        issue(0, 8'h00, 8'h00, 8'h30, 8'h00);
        check("R8 reach meet taken", 8'h30, t, 1, 0);
        issue(1, 8'hFF, 8'h77, 8'h55, 8'h66);   // ignored: settle
        check("R9 R8 restore fall path", 8'h11, ~t, 0, 0);
        issue(0, 8'h00, 8'h00, 8'h30, 8'h00);
        check("R8 reach meet fall", 8'h30, ~t, 1, 0);
        idle();
        check("R8 merged", 8'h30, 8'hFF, 0, 0);
      end
    end

    // nested splits, inactive lane bits
    launch(8'h10);
    issue(1, 8'h0F, 8'h20, 8'h11, 8'h30);
    check("R7 outer", 8'h20, 8'h0F, 0, 0);
    issue(1, 8'h3F, 8'h40, 8'h21, 8'h50);
    check("R6 R4 inactive bits set", 8'h40, 8'h0F, 0, 0);
    issue(1, 8'hF0, 8'h44, 8'h41, 8'h50);
    check("R6 R5 inactive bits only", 8'h41, 8'h0F, 0, 0);
    issue(1, 8'h03, 8'h50, 8'h51, 8'h60);
    check("R11 inner split", 8'h50, 8'h03, 0, 0);
    issue(0, 8'h00, 8'h00, 8'h60, 8'h00);
    check("R11 inner meet", 8'h60, 8'h03, 1, 0);
    idle();
    check("R11 inner fall", 8'h51, 8'h0C, 0, 0);
    issue(0, 8'h00, 8'h00, 8'h60, 8'h00);
    check("R11 inner meet2", 8'h60, 8'h0C, 1, 0);
    idle();
    check("R11 inner merged", 8'h60, 8'h0F, 0, 0);
    issue(0, 8'h00, 8'h00, 8'h30, 8'h00);
    check("R11 outer meet", 8'h30, 8'h0F, 1, 0);
    idle();
    check("R11 outer fall", 8'h11, 8'hF0, 0, 0);
    issue(0, 8'h00, 8'h00, 8'h30, 8'h00);
    idle();
    check("R11 outer merged", 8'h30, 8'hFF, 0, 0);

    // overflow: two splits fill DEPTH=4
    launch(8'h10);
    issue(1, 8'h0F, 8'h20, 8'h11, 8'h30);
    issue(1, 8'h03, 8'h50, 8'h51, 8'h60);
    check("R10 full no flag", 8'h50, 8'h03, 0, 0);
    issue(1, 8'h01, 8'h70, 8'h71, 8'h72);
    check("R10 overflow", 8'h50, 8'h03, 0, 1);
    issue(0, 8'h00, 8'h00, 8'h52, 8'h00);
    check("R10 sticky", 8'h52, 8'h03, 0, 1);
    launch(8'h10);
    check("R2 clears overflow", 8'h10, 8'hFF, 0, 0);

    // start beats a split in the same cycle
    start_i = 1; start_pc_i = 8'h90;
    issue(1, 8'h0F, 8'h20, 8'h11, 8'h30);
    start_i = 0;
    check("R2 start over split", 8'h90, 8'hFF, 0, 0);

    // start beats a pending restore; stack emptied
    launch(8'h10);
    issue(1, 8'h0F, 8'h20, 8'h11, 8'h30);
    issue(0, 8'h00, 8'h00, 8'h30, 8'h00);
    check("R8 settle before start", 8'h30, 8'h0F, 1, 0);
    launch(8'h80);
    check("R2 start over restore", 8'h80, 8'hFF, 0, 0);
    issue(0, 8'h00, 8'h00, 8'h30, 8'h00);
    check("R2 stack emptied", 8'h30, 8'hFF, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule